// File: doc/BRIEF.md
# Halting Clock Divider with Slow Mode

This block derives three output clocks from one input clock and lets the system slow them down or halt them. The input `clk_i` is the edge clock: it runs at twice the base oscillator rate, so each of its rising edges stands for one edge of the base oscillator. In this text an "edge" is one `clk_i` cycle, and one base cycle is two edges. This keeps every half-cycle duty point on a single rising-edge register.

`clk_o` is the processor clock with a one-third high time. `clk50_o` runs at the same rate with a half high time, and both fall on the same edge. `pclk_o` is a peripheral clock at base/6 that ignores the speed mode. A filtered speed-select input chooses between base/3 and base/768. A change of speed is applied only where a processor-clock period ends, so no shortened pulse appears.

Three status inputs are sampled each time `clk_o` rises. When a halt pattern is decoded, the block finishes two more processor-clock cycles and then freezes. A run-enable input restarts the clocks from phase zero, in the mode they had when they stopped. A synchronisation input clears every divider and holds all three clocks high, so that several copies of the block can be phase-aligned.

Top module: `clkgen_ctrl`

## Requirements
- R1: While `rst_n_i` is low, and in the cycle after it is released, `clk_o`, `clk50_o`, `pclk_o` and `stop_req_o` are 0 and the speed mode is fast.
- R2: In fast mode the `clk_o` period is 6 edges. `clk_o` is high for the last 2 edges of the period and `clk50_o` for the last 3, and both fall on the same edge.
- R3: In slow mode the period is 1536 edges (base/768). `clk_o` is high for the last 512 edges and `clk50_o` for the last 768.
- R4: `pclk_o` toggles every 6 edges in either mode, counted from reset, restart or the end of a sync hold, which gives a 12-edge period with a 50% duty cycle.
- R5: `slo_fst_i` low (slow request) takes hold only after 390 consecutive low edges (195 base cycles). High (fast request) takes hold after 6 consecutive high edges (3 base cycles). Shorter pulses leave the mode unchanged.
- R6: A recognised speed change is applied only on the edge where a `clk_o` period ends. That edge is always also a `pclk_o` edge.
- R7: `stat_i` = {s2,s1,s0} is sampled on each `clk_o` rising edge. A halt is decoded when the sample is 3'b011, the previous rising-edge sample was 3'b111, and `run_en_i` is low.
- R8: After a decode, the clocks run until the second following `clk_o` rising edge. From then on `clk_o` and `clk50_o` stay high, `pclk_o` holds its level, and `stop_req_o` is 1.
- R9: With `run_en_i` high while stopped, the next edge clears `stop_req_o` and restarts all three clocks from phase zero in the mode in use before the halt. While `run_en_i` is high, a pending halt is cancelled and no halt is decoded.
- R10: On each edge where `csync_i` is high, all dividers are cleared, any halt is cancelled, and the three clocks are driven high. Counting restarts from phase zero once `csync_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Edge clock, twice the base rate |
| rst_n_i | input | 1 | Active-low synchronous reset |
| run_en_i | input | 1 | Restart request, level sensitive |
| slo_fst_i | input | 1 | Speed select, high = fast |
| stat_i | input | 3 | Status lines {s2,s1,s0} |
| csync_i | input | 1 | Divider clear and output hold |
| clk_o | output | 1 | One-third duty processor clock |
| clk50_o | output | 1 | Half duty processor-rate clock |
| pclk_o | output | 1 | Peripheral clock, base/6 |
| stop_req_o | output | 1 | Clocks halted |

## Verification
A cycle-level reference model in the bench follows every edge. Directed phases cover each main case. Steady fast and slow running checks the period and the duty points. A speed-select pulse just one edge shorter than the slow threshold must be ignored. A 3'b111 to 3'b011 pair on consecutive rises must halt the clocks, while 3'b010 followed by 3'b011 must not. A restart issued while a fast request is pending must resume in slow mode. After that, random sequences of status patterns, run pulses, sync pulses and speed toggles check how halt, restart and resynchronisation interact at arbitrary phases.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  typedef enum logic {SPD_FAST = 1'b0, SPD_SLOW = 1'b1} speed_t;
  localparam int PHASES      = 6;
  localparam int PH_W        = $clog2(PHASES);
  localparam int CLK_HI_FROM = PHASES * 2 / 3;
  localparam int C50_HI_FROM = PHASES / 2;
  localparam logic [2:0] STAT_IDLE = 3'b111;
  localparam logic [2:0] STAT_HALT = 3'b011;
endpackage

// File: rtl/speed_filter.sv
`timescale 1ns/1ps
module speed_filter
  import clkgen_pkg::*;
#(
  parameter int SLOW_HOLD = 390,
  parameter int FAST_HOLD = 6
) (
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   sel_i,
  output speed_t speed_o
);
  localparam int MAXH  = (SLOW_HOLD > FAST_HOLD) ? SLOW_HOLD : FAST_HOLD;
  localparam int CNT_W = $clog2(MAXH + 1);
  localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_HOLD - 1);
  localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_HOLD - 1);

  speed_t           speed_q;
  speed_t           target;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    target = sel_i ? SPD_FAST : SPD_SLOW;
    lim    = (target == SPD_SLOW) ? SLOW_LIM : FAST_LIM;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      speed_q <= SPD_FAST;
      cnt_q   <= '0;
    end else if (target == speed_q) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      speed_q <= target;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign speed_o = speed_q;

  assert_filter_held_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(speed_q) |-> ($past(sel_i) == $past(sel_i, 2)) &&
                          ($past(sel_i) == (speed_q == SPD_FAST)));
endmodule

// File: rtl/halt_ctrl.sv
`timescale 1ns/1ps
module halt_ctrl
  import clkgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic       rise_i,
  input  logic [2:0] stat_i,
  output logic       halted_o
);
  logic prev_idle_q;
  logic pend_q;
  logic seen_q;
  logic halted_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i || clear_i) begin
      prev_idle_q <= 1'b0;
      pend_q      <= 1'b0;
      seen_q      <= 1'b0;
      halted_q    <= 1'b0;
    end else if (halted_q) begin
      if (run_i) begin
        halted_q    <= 1'b0;
        prev_idle_q <= 1'b0;
      end
    end else begin
      if (run_i) pend_q <= 1'b0;
      if (rise_i) begin
        prev_idle_q <= (stat_i == STAT_IDLE);
        if (pend_q && !run_i) begin
          if (seen_q) begin
            halted_q <= 1'b1;
            pend_q   <= 1'b0;
          end else begin
            seen_q <= 1'b1;
          end
        end else if (!pend_q && !run_i && prev_idle_q && stat_i == STAT_HALT) begin
          pend_q <= 1'b1;
          seen_q <= 1'b0;
        end
      end
    end
  end

  assign halted_o = halted_q;

  assert_halt_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(halted_q) |-> $past(rise_i) && !$past(run_i));
  assert_no_decode_in_run_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    run_i && !halted_q |=> !$rose(pend_q));
endmodule

// File: rtl/clk_phase.sv
`timescale 1ns/1ps
module clk_phase
  import clkgen_pkg::*;
#(
  parameter int SLOW_PRESCALE = 256
) (
  input  logic   clk_i,
  input  logic   rst_n_i,
  input  logic   sync_i,
  input  logic   halt_i,
  input  logic   restart_i,
  input  speed_t speed_sel_i,
  output logic   rise_o,
  output logic   clk_o,
  output logic   clk50_o,
  output logic   pclk_o
);
  localparam int PRE_W = (SLOW_PRESCALE > 1) ? $clog2(SLOW_PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_PRESCALE - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(CLK_HI_FROM - 1);
  localparam logic [PH_W-1:0]  PH_CLK   = PH_W'(CLK_HI_FROM);
  localparam logic [PH_W-1:0]  PH_C50   = PH_W'(C50_HI_FROM);

  logic [PH_W-1:0]  ph_q, ph_n, per_q, per_n;
  logic [PRE_W-1:0] pre_q, pre_n;
  logic             pclk_q, pclk_n;
  speed_t           mode_q, mode_n;
  logic             clk_q, clk50_q, adv;

  always_comb begin
    adv    = !halt_i && !sync_i && ((mode_q == SPD_FAST) || (pre_q == PRE_LAST));
    rise_o = adv && (ph_q == PH_RISE);
    ph_n   = ph_q;
    pre_n  = pre_q;
    per_n  = per_q;
    pclk_n = pclk_q;
    mode_n = mode_q;
    if (sync_i) begin
      ph_n   = '0;
      pre_n  = '0;
      per_n  = '0;
      pclk_n = 1'b1;
    end else if (restart_i) begin
      ph_n  = '0;
      pre_n = '0;
      per_n = '0;
    end else if (!halt_i) begin
      if (mode_q == SPD_SLOW) pre_n = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      else                    pre_n = '0;
      if (adv) begin
        if (ph_q == PH_LAST) begin
          ph_n   = '0;
          mode_n = speed_sel_i;
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      if (per_q == PH_LAST) begin
        per_n  = '0;
        pclk_n = ~pclk_q;
      end else begin
        per_n = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      ph_q    <= '0;
      pre_q   <= '0;
      per_q   <= '0;
      pclk_q  <= 1'b0;
      mode_q  <= SPD_FAST;
      clk_q   <= 1'b0;
      clk50_q <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      pre_q   <= pre_n;
      per_q   <= per_n;
      pclk_q  <= pclk_n;
      mode_q  <= mode_n;
      clk_q   <= sync_i | (ph_n >= PH_CLK);
      clk50_q <= sync_i | (ph_n >= PH_C50);
    end
  end

  assign clk_o   = clk_q;
  assign clk50_o = clk50_q;
  assign pclk_o  = pclk_q;

  assert_fall_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(clk_q) |-> $fell(clk50_q));
  assert_mode_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(mode_q) |-> $fell(clk_q));
endmodule

// File: rtl/clkgen_ctrl.sv
`timescale 1ns/1ps
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int SLOW_PRESCALE  = 256,
  parameter int SLOW_HOLD_BASE = 195,
  parameter int FAST_HOLD_BASE = 3
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic       run_en_i,
  input  logic       slo_fst_i,
  input  logic [2:0] stat_i,
  input  logic       csync_i,
  output logic       clk_o,
  output logic       clk50_o,
  output logic       pclk_o,
  output logic       stop_req_o
);
  localparam int SLOW_HOLD = 2 * SLOW_HOLD_BASE;
  localparam int FAST_HOLD = 2 * FAST_HOLD_BASE;

  speed_t speed_sel;
  logic   halted, rise, restart;

  assign restart = halted & run_en_i;

  speed_filter #(.SLOW_HOLD(SLOW_HOLD), .FAST_HOLD(FAST_HOLD)) u_filt (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .sel_i(slo_fst_i), .speed_o(speed_sel));

  halt_ctrl u_halt (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .clear_i(csync_i), .run_i(run_en_i),
    .rise_i(rise), .stat_i(stat_i), .halted_o(halted));

  clk_phase #(.SLOW_PRESCALE(SLOW_PRESCALE)) u_phase (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .sync_i(csync_i), .halt_i(halted),
    .restart_i(restart), .speed_sel_i(speed_sel), .rise_o(rise),
    .clk_o(clk_o), .clk50_o(clk50_o), .pclk_o(pclk_o));

  assign stop_req_o = halted;

  assert_halted_high_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_req_o |-> clk_o && clk50_o);
  assert_pclk_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_req_o && $past(stop_req_o) |-> $stable(pclk_o));
  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_req_o && run_en_i && !csync_i |=> !stop_req_o && !clk_o && !clk50_o);
  assert_sync_high_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    csync_i |=> clk_o && clk50_o && pclk_o && !stop_req_o);
endmodule

// File: tb/sim_clkgen_ctrl.sv
`timescale 1ns/1ps
module sim_clkgen_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0, run = 1'b0, sf = 1'b1, cs = 1'b0;
  logic [2:0] st = 3'b111;
  logic       o_clk, o_c50, o_pclk, o_stop;

  clkgen_ctrl u0 (.clk_i(clk), .rst_n_i(rst_n), .run_en_i(run), .slo_fst_i(sf),
    .stat_i(st), .csync_i(cs), .clk_o(o_clk), .clk50_o(o_c50), .pclk_o(o_pclk),
    .stop_req_o(o_stop));

  int    n_vec = 0, n_err = 0;
  string req = "R1";
  bit    done = 0;

  // reference model state, in edges
  int mt, me6, mpclk, mfilt, mfcnt, mhalt, mpend, mrcnt, mprev, mhold, mm;

  function automatic int plen(int m);
    return (m != 0) ? 1536 : 6;
  endfunction

  task automatic model_reset();
    mt = 0; me6 = 0; mpclk = 0; mfilt = 0; mfcnt = 0; mhalt = 0;
    mpend = 0; mrcnt = 0; mprev = 0; mhold = 0; mm = 0;
  endtask

  task automatic model_step();
    int L, oldprev, tgt, lim;
    bit rise, endp;
    if (cs) begin
      mt = 0; me6 = 0; mpclk = 1; mhold = 1; mhalt = 0; mpend = 0; mrcnt = 0; mprev = 0;
    end else begin
      mhold = 0;
      if (mhalt != 0) begin
        if (run) begin mhalt = 0; mprev = 0; mt = 0; me6 = 0; end
      end else begin
        L = plen(mm);
        rise = (mt == L * 2 / 3 - 1);
        endp = (mt == L - 1);
        if (run) mpend = 0;
        if (rise) begin
          oldprev = mprev;
          mprev = (st == 3'b111);
          if (mpend != 0 && !run) begin
            if (mrcnt != 0) begin mhalt = 1; mpend = 0; end else mrcnt = 1;
          end else if (mpend == 0 && !run && oldprev != 0 && st == 3'b011) begin
            mpend = 1; mrcnt = 0;
          end
        end
        if (endp) begin mt = 0; mm = mfilt; end else mt = mt + 1;
        if (me6 == 5) begin me6 = 0; mpclk = 1 - mpclk; end else me6 = me6 + 1;
      end
    end
    tgt = sf ? 0 : 1;
    lim = (tgt != 0) ? 390 : 6;
    if (tgt == mfilt) mfcnt = 0;
    else if (mfcnt == lim - 1) begin mfilt = tgt; mfcnt = 0; end
    else mfcnt = mfcnt + 1;
  endtask

  task automatic check();
    logic e_clk, e_c50, e_pclk, e_stop;
    int L;
    L = plen(mm);
    e_clk  = (mhold != 0) || (mt >= L * 2 / 3);
    e_c50  = (mhold != 0) || (mt >= L / 2);
    e_pclk = (mpclk != 0);
    e_stop = (mhalt != 0);
    n_vec++;
    if ({o_clk, o_c50, o_pclk, o_stop} !== {e_clk, e_c50, e_pclk, e_stop}) begin
      n_err++;
      $display("FAIL %s: clk,clk50,pclk,stop got %b%b%b%b expected %b%b%b%b at %0t",
               req, o_clk, o_c50, o_pclk, o_stop, e_clk, e_c50, e_pclk, e_stop, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      check();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    req = "R1 reset state";
    check();
    rst_n = 1'b1;
    req = "R1 after release"; step(1);
    req = "R2 fast run";      step(60);
    req = "R4 pclk fast";     step(24);
    // filter: 389 low edges must not switch
    req = "R5 short slow request"; sf = 1'b0; step(389);
    sf = 1'b1; step(30);
    req = "R5 slow request"; sf = 1'b0; step(392);
    req = "R6 switch to slow"; step(20);
    req = "R3 slow run"; step(3200);
    req = "R4 pclk slow"; step(100);
    // qualified halt in slow mode
    req = "R7 idle before halt"; st = 3'b111; step(1600);
    req = "R7 halt pattern"; st = 3'b011; step(4000);
    req = "R8 frozen"; step(200);
    req = "R5 fast request during halt"; sf = 1'b1; step(20);
    req = "R9 restart keeps slow"; run = 1'b1; step(1); run = 1'b0; step(1700);
    req = "R6 switch to fast"; step(40);
    // unqualified halt
    req = "R7 unqualified"; st = 3'b010; step(20); st = 3'b011; step(30);
    req = "R7 qualified fast"; st = 3'b111; step(10); st = 3'b011; step(30);
    req = "R9 restart fast"; run = 1'b1; step(1); run = 1'b0; step(20);
    req = "R9 run blocks decode"; run = 1'b1; st = 3'b111; step(10);
    st = 3'b011; step(20); run = 1'b0; step(10);
    req = "R10 sync hold"; cs = 1'b1; step(5); cs = 1'b0; step(30);
    req = "R10 sync during halt"; st = 3'b111; step(10); st = 3'b011; step(30);
    cs = 1'b1; step(3); cs = 1'b0; step(30);
    // random mix
    req = "R7 R8 R9 R10 random";
    for (int k = 0; k < 8000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      cs  = (r == 0);
      run = (r >= 1 && r <= 3);
      r = $urandom_range(0, 15);
      if (r < 11)       st = 3'b111;
      else if (r < 14)  st = 3'b011;
      else              st = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 199) == 0) sf = ~sf;
      step($urandom_range(1, 8));
    end
    cs = 1'b0; run = 1'b0; st = 3'b111;
    step(10);
    finish_run();
  end
endmodule